// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Set Execution Unit

This unit executes the second byte of a prefixed bit-manipulation opcode for an 8-bit processor core. It splits the byte into an operation field and an operand selector. It then rotates or shifts the supplied 8-bit operand, or forces one bit of it to 1. It also produces the flag byte, the destination selector, the effective memory address and the number of machine cycles the instruction takes.

The surrounding core fetches the operand and presents it along with the opcode byte and the current flag byte. When the operand lives in memory, the core also supplies a pointer base and, for the indexed form, a displacement byte. One clock after a single-cycle `issue` strobe, every output is registered and `res_valid` pulses. The core then writes `result` back through `dest_sel` and commits `flags_out`. Register-file access, memory access and the fetch of the displacement byte are left to the core.

Top module: `srb_unit`

## Requirements
- R1: `dest_sel` equals opcode bits 2:0, with operand codes B=000, C=001, D=010, E=011, H=100, L=101, memory at the pointer=110 and A=111.
- R2: With bits 7:6 = 00, operation 000 rotates left and operation 001 rotates right, both circularly. The bit that leaves the byte enters the opposite end and also becomes the carry.
- R3: With bits 7:6 = 00, operation 010 rotates left through carry and operation 011 rotates right through carry. The old carry (flags_in bit 0) enters the vacated end, and the bit that leaves becomes the new carry.
- R4: With bits 7:6 = 00, three shifts are decoded, and in each the bit that leaves goes to carry:
  - operation 100 shifts left and fills bit 0 with 0;
  - operation 101 shifts right and keeps bit 7;
  - operation 111 shifts right and fills bit 7 with 0.
- R5: For every rotate and shift, the flag byte is built as follows: bit 7 (sign) takes result bit 7; bit 6 (zero) is set when the result is 0; bit 2 (parity) is set on even parity; bits 4 (half carry) and 1 (subtract) are cleared; bit 0 holds the new carry; bits 5 and 3 are copied from flags_in.
- R6: A byte of the form 11bbbrrr sets bit bbb of the operand, where bit 0 is the least significant bit, and leaves the other bits alone. Its flags output equals flags_in. For example, DAh sets bit 3 with destination D, and EEh sets bit 5 of memory.
- R7: `cycles` is 8 for a register operand and 15 for operand code 110. When `use_index` is 1 it is 23, whatever the operand code.
- R8: `mem_addr` is `ptr_base` plus `disp` sign-extended as a two's-complement byte when `use_index` is 1, and `ptr_base` otherwise.
- R9: Bytes 00110rrr, 01xxxxxx and 10xxxxxx set `unsupported` to 1 and return `result` equal to the operand and `flags_out` equal to flags_in. All other bytes give `unsupported` = 0.
- R10: Outputs update on the clock edge that samples `issue`=1, and `res_valid` is high for exactly that one following cycle. Without `issue`, all data outputs hold their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Accepts the current opcode and operand this cycle |
| op_byte | input | 8 | Second opcode byte |
| opnd | input | 8 | Operand value fetched by the core |
| flags_in | input | 8 | Current flag byte, carry in bit 0 |
| use_index | input | 1 | Operand is an indexed memory byte |
| ptr_base | input | ADDR_W | Pointer or index register value |
| disp | input | 8 | Signed displacement for the indexed form |
| res_valid | output | 1 | Outputs below are fresh this cycle |
| result | output | 8 | Operation result |
| dest_sel | output | 3 | Destination operand code |
| flags_out | output | 8 | New flag byte |
| cycles | output | CYC_W | Machine cycles taken |
| mem_addr | output | ADDR_W | Effective memory address |
| unsupported | output | 1 | Opcode byte not handled by this unit |

## Verification
Each output is produced by one register stage from the decoded byte, so a decode or datapath fault shows up on `result`, `flags_out` or `cycles` in the cycle right after the issuing edge. Misdecoding the operation field corrupts `result` or the carry bit. A wrong bit index in the set path shows as a missing or extra set bit. A stale hold register shows as outputs that change without `issue`. The bench compares every issued byte against its own model, covering all operand codes, carry values and both displacement signs.

// File: rtl/srb_pkg.sv
package srb_pkg;

    typedef enum logic [2:0] {
        K_ROL_C = 3'b000,
        K_ROR_C = 3'b001,
        K_ROL_T = 3'b010,
        K_ROR_T = 3'b011,
        K_SHL_A = 3'b100,
        K_SHR_A = 3'b101,
        K_HOLE  = 3'b110,
        K_SHR_L = 3'b111
    } shop_e;

    typedef struct packed {
        logic       is_shift;
        logic       is_set;
        logic       unsup;
        shop_e      op;
        logic [2:0] bitn;
        logic [2:0] sel;
        logic       is_mem;
    } dec_t;

    localparam logic [2:0] SEL_MEM = 3'b110;

    function automatic logic even_par(input logic [7:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/srb_decode.sv
module srb_decode
    import srb_pkg::*;
(
    input  logic [7:0] op_byte,
    output dec_t       dec
);
    logic [1:0] grp;
    assign grp = op_byte[7:6];

    always_comb begin
        dec          = '0;
        dec.op       = shop_e'(op_byte[5:3]);
        dec.bitn     = op_byte[5:3];
        dec.sel      = op_byte[2:0];
        dec.is_mem   = (op_byte[2:0] == SEL_MEM);
        unique case (grp)
            2'b00: begin
                if (op_byte[5:3] == K_HOLE) dec.unsup    = 1'b1;
                else                        dec.is_shift = 1'b1;
            end
            2'b11:   dec.is_set = 1'b1;
            default: dec.unsup  = 1'b1;
        endcase
    end
endmodule

// File: rtl/srb_alu.sv
module srb_alu
    import srb_pkg::*;
#(
    parameter int DW = 8
) (
    input  dec_t          dec,
    input  logic [DW-1:0] v,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic [DW-1:0] mask;

    // one-hot mask for the set-bit form
    for (genvar g = 0; g < DW; g++) begin : g_mask
        assign mask[g] = (dec.bitn == 3'(g));
    end

    always_comb begin
        res  = v;
        cout = cin;
        if (dec.is_shift) begin
            unique case (dec.op)
                K_ROL_C: begin res = {v[DW-2:0], v[DW-1]}; cout = v[DW-1]; end
                K_ROR_C: begin res = {v[0], v[DW-1:1]};    cout = v[0];    end
                K_ROL_T: begin res = {v[DW-2:0], cin};     cout = v[DW-1]; end
                K_ROR_T: begin res = {cin, v[DW-1:1]};     cout = v[0];    end
                K_SHL_A: begin res = {v[DW-2:0], 1'b0};    cout = v[DW-1]; end
                K_SHR_A: begin res = {v[DW-1], v[DW-1:1]}; cout = v[0];    end
                K_SHR_L: begin res = {1'b0, v[DW-1:1]};    cout = v[0];    end
                default: begin res = v;                    cout = cin;     end
            endcase
        end else if (dec.is_set) begin
            res = v | mask;
        end
    end
endmodule

// File: rtl/srb_addr_cyc.sv
module srb_addr_cyc #(
    parameter int ADDR_W  = 16,
    parameter int REG_CYC = 8,
    parameter int PTR_CYC = 15,
    parameter int IDX_CYC = 23,
    parameter int CYC_W   = 5
) (
    input  logic              is_mem,
    input  logic              use_index,
    input  logic [ADDR_W-1:0] ptr_base,
    input  logic [7:0]        disp,
    output logic [ADDR_W-1:0] addr,
    output logic [CYC_W-1:0]  cyc
);
    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs = use_index ? {{(ADDR_W-8){disp[7]}}, disp} : '0;
        addr = ptr_base + offs;
        if (use_index)   cyc = CYC_W'(IDX_CYC);
        else if (is_mem) cyc = CYC_W'(PTR_CYC);
        else             cyc = CYC_W'(REG_CYC);
    end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
    import srb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int REG_CYC = 8,
    parameter int PTR_CYC = 15,
    parameter int IDX_CYC = 23,
    localparam int CYC_W  = $clog2(IDX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        opnd,
    input  logic [7:0]        flags_in,
    input  logic              use_index,
    input  logic [ADDR_W-1:0] ptr_base,
    input  logic [7:0]        disp,
    output logic              res_valid,
    output logic [7:0]        result,
    output logic [2:0]        dest_sel,
    output logic [7:0]        flags_out,
    output logic [CYC_W-1:0]  cycles,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              unsupported
);
    typedef struct packed {
        logic              valid;
        logic [7:0]        res;
        logic [2:0]        dst;
        logic [7:0]        flg;
        logic [CYC_W-1:0]  cyc;
        logic [ADDR_W-1:0] addr;
        logic              unsup;
    } st_t;

    st_t st_d, st_q;

    dec_t              dec;
    logic [7:0]        alu_res;
    logic              alu_c;
    logic [ADDR_W-1:0] ac_addr;
    logic [CYC_W-1:0]  ac_cyc;

    srb_decode u_dec (.op_byte(op_byte), .dec(dec));

    srb_alu #(.DW(8)) u_alu (
        .dec(dec), .v(opnd), .cin(flags_in[0]), .res(alu_res), .cout(alu_c)
    );

    srb_addr_cyc #(
        .ADDR_W(ADDR_W), .REG_CYC(REG_CYC), .PTR_CYC(PTR_CYC),
        .IDX_CYC(IDX_CYC), .CYC_W(CYC_W)
    ) u_ac (
        .is_mem(dec.is_mem), .use_index(use_index), .ptr_base(ptr_base),
        .disp(disp), .addr(ac_addr), .cyc(ac_cyc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (issue) begin
            st_d.valid = 1'b1;
            st_d.res   = alu_res;
            st_d.dst   = dec.sel;
            st_d.cyc   = ac_cyc;
            st_d.addr  = ac_addr;
            st_d.unsup = dec.unsup;
            st_d.flg   = flags_in;
            if (dec.is_shift) begin
                st_d.flg[7] = alu_res[7];
                st_d.flg[6] = (alu_res == 8'h00);
                st_d.flg[4] = 1'b0;
                st_d.flg[2] = even_par(alu_res);
                st_d.flg[1] = 1'b0;
                st_d.flg[0] = alu_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid   = st_q.valid;
    assign result      = st_q.res;
    assign dest_sel    = st_q.dst;
    assign flags_out   = st_q.flg;
    assign cycles      = st_q.cyc;
    assign mem_addr    = st_q.addr;
    assign unsupported = st_q.unsup;

    AST_UNSUP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op_byte[7:6] == 2'b01 || op_byte[7:6] == 2'b10) |=>
            unsupported && result == $past(opnd) && flags_out == $past(flags_in)); // R9

    AST_SETBIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op_byte[7:6] == 2'b11 |=>
            flags_out == $past(flags_in) && result[$past(op_byte[5:3])]); // R6

    AST_SHIFT_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op_byte[7:6] == 2'b00 && op_byte[5:3] != 3'b110 |=>
            !flags_out[4] && !flags_out[1] && flags_out[6] == (result == 8'h00)); // R5

    AST_CYCLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> cycles == CYC_W'(REG_CYC) || cycles == CYC_W'(PTR_CYC)
               || cycles == CYC_W'(IDX_CYC)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid && $stable(result) && $stable(flags_out)); // R10

    AST_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> dest_sel == $past(op_byte[2:0])); // R1
endmodule

// File: tb/sim_srb_unit.sv
module sim_srb_unit;
    localparam int  AW    = 16;
    localparam time TCLK  = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue = 1'b0;
    logic [7:0]    op_byte = '0, opnd = '0, flags_in = '0, disp = '0;
    logic          use_index = 1'b0;
    logic [AW-1:0] ptr_base = '0;
    logic          res_valid, unsupported;
    logic [7:0]    result, flags_out;
    logic [2:0]    dest_sel;
    logic [4:0]    cycles;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(TCLK/2) clk = ~clk;

    srb_unit u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%h opnd=%h: actual %h expected %h", req, op_byte, opnd, act, exp);
        end
    endtask

    // bench model: returns {unsup, carry, result}
    function automatic logic [9:0] model(input logic [7:0] op, input logic [7:0] v, input logic c);
        logic [7:0] r; logic co; logic un;
        r = v; co = c; un = 1'b0;
        if (op[7:6] == 2'b11) r = v | (8'h01 << op[5:3]);
        else if (op[7:6] != 2'b00 || op[5:3] == 3'b110) un = 1'b1;
        else case (op[5:3])
            3'd0: begin r = (v << 1) | (v >> 7); co = v[7]; end      // R2
            3'd1: begin r = (v >> 1) | (v << 7); co = v[0]; end      // R2
            3'd2: begin r = (v << 1) | 8'(c);    co = v[7]; end      // R3
            3'd3: begin r = (v >> 1) | {c, 7'b0}; co = v[0]; end     // R3
            3'd4: begin r = v << 1;              co = v[7]; end      // R4
            3'd5: begin r = (v >> 1) | (v & 8'h80); co = v[0]; end   // R4
            default: begin r = v >> 1;           co = v[0]; end      // R4
        endcase
        return {un, co, r};
    endfunction

    task automatic run_one(input logic [7:0] op, input logic [7:0] v, input logic [7:0] f,
                           input logic ix, input logic [AW-1:0] base, input logic [7:0] d);
        logic [9:0] m; logic [7:0] ef; int ec; logic [AW-1:0] ea;
        @(negedge clk);
        op_byte = op; opnd = v; flags_in = f; use_index = ix; ptr_base = base; disp = d;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        m  = model(op, v, f[0]);
        ef = f;
        if (op[7:6] == 2'b00 && op[5:3] != 3'b110) begin
            ef[7] = m[7]; ef[6] = (m[7:0] == 0); ef[4] = 0;
            ef[2] = ~(^m[7:0]); ef[1] = 0; ef[0] = m[8];
        end
        ec = ix ? 23 : (op[2:0] == 3'b110 ? 15 : 8);
        ea = ix ? base + {{(AW-8){d[7]}}, d} : base;
        check("R10 valid", 32'(res_valid), 1);
        check("R1/R2/R3/R4/R6 result", 32'(result), 32'(m[7:0]));
        check("R1 dest", 32'(dest_sel), 32'(op[2:0]));
        check("R5/R6 flags", 32'(flags_out), 32'(ef));
        check("R7 cycles", 32'(cycles), 32'(ec));
        check("R8 addr", 32'(mem_addr), 32'(ea));
        check("R9 unsupported", 32'(unsupported), 32'(m[9]));
    endtask

    initial begin
        logic [7:0] keep_r, keep_f;
        void'($urandom(32'd4242));
        #(TCLK*3);
        @(negedge clk);
        check("R10 reset valid", 32'(res_valid), 0);
        check("R10 reset result", 32'(result), 0);
        check("R10 reset cycles", 32'(cycles), 0);
        check("R10 reset addr", 32'(mem_addr), 0);
        rst_n = 1'b1;

        run_one(8'hDA, 8'h00, 8'h55, 0, 16'h1000, 8'h00);   // R6 set bit 3 of D
        run_one(8'hEE, 8'h01, 8'hAA, 0, 16'h2000, 8'h00);   // R6 bit 5, memory, R7 15
        run_one(8'h10, 8'h80, 8'h00, 0, 16'h0,    8'h00);   // R3 RL -> zero, carry
        run_one(8'h18, 8'h01, 8'h01, 0, 16'h0,    8'h00);   // R3 RR with carry in
        run_one(8'h00, 8'h81, 8'h00, 0, 16'h0,    8'h00);   // R2
        run_one(8'h0F, 8'h01, 8'h00, 0, 16'h0,    8'h00);   // R2 A
        run_one(8'h28, 8'h81, 8'hFF, 0, 16'h0,    8'h00);   // R4 arith right keeps b7
        run_one(8'h3F, 8'h81, 8'hFF, 0, 16'h0,    8'h00);   // R4 logical right
        run_one(8'h20, 8'hC0, 8'h28, 0, 16'h0,    8'h00);   // R4/R5 bits 5,3 pass
        run_one(8'h16, 8'h44, 8'h00, 1, 16'h2000, 8'h80);   // R8 negative disp, R7 23
        run_one(8'hC6, 8'h00, 8'h00, 1, 16'h2000, 8'h03);   // R8 positive disp
        run_one(8'h30, 8'h5A, 8'hC3, 0, 16'h0,    8'h00);   // R9 hole
        run_one(8'h47, 8'hA5, 8'h11, 0, 16'h0,    8'h00);   // R9 group 01
        run_one(8'h9E, 8'h3C, 8'h22, 0, 16'h0,    8'h00);   // R9 group 10

        // R10: no issue -> outputs hold
        keep_r = result; keep_f = flags_out;
        op_byte = 8'h07; opnd = 8'hFF; flags_in = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 idle valid", 32'(res_valid), 0);
        check("R10 hold result", 32'(result), 32'(keep_r));
        check("R10 hold flags", 32'(flags_out), 32'(keep_f));

        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (i % 3 != 0) op[7:6] = (i % 2) ? 2'b00 : 2'b11;
            run_one(op, 8'($urandom), 8'($urandom), 1'($urandom),
                    16'($urandom), 8'($urandom));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(TCLK*100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule